// File: doc/BRIEF.md
# Nested Interrupt Priority Resolver

This block is the decision core of an eight-level interrupt controller. Request pulses from the interrupt sources are held in a pending register. Unmasked pending requests are weighed against the levels already in service, and at most one interrupt line to the processor is raised at a time. Level 0 has the highest priority and level 7 the lowest. While the line is up and not yet acknowledged, the chosen level is frozen. The processor's acknowledge moves that level into the in-service register. Software then retires in-service levels with end-of-interrupt commands, either "the most urgent one" or "this particular one".

Two comparison modes are supported. In nested mode, a level already in service blocks itself and every less urgent level. In special-mask mode, only a level's own in-service bit blocks it, so lower levels can be served during a long high-priority handler. A source that withdraws its request can erase its pending bit, but only while that level is masked. The arbitration is re-run every clock cycle on the registered state.

Top module: `nest_prio_resolver`

## Requirements
- R1: Among eligible requests, the one with the lowest level index is selected. `sel_level` carries that index as an unsigned binary number.
- R2: A high bit in `req_set` sets the matching pending bit (`irr_out`) at the next clock edge. If the same bit is cleared in the same cycle by an untrigger or by selection, the set takes precedence.
- R3: A high bit in `req_clr` clears the matching pending bit at the next edge only if `mask_in` has that bit set. For an unmasked level, the untrigger has no effect on `irr_out`.
- R4: A level whose `mask_in` bit is 1 is never selected. While `int_out` is high and `ack` is low, no new selection is made and `sel_level` stays constant.
- R5: With `special_mask` low, a request is eligible only when its level is below the lowest-numbered set bit of `isr_out`. When `isr_out[0]` is set, nothing is eligible.
- R6: With `special_mask` high, an unmasked request is eligible whenever its own `isr_out` bit is clear, whatever other levels are in service.
- R7: If `int_out` is low and an eligible request exists at a clock edge, then after that edge `int_out` is 1, `sel_level` holds the winner, and the winner's pending bit is clear (unless R2 applies).
- R8: `ack` while `int_out` is high drops `int_out` at the next edge and sets the `isr_out` bit of `sel_level`. `ack` while `int_out` is low has no effect.
- R9: `eoi_lowest` clears the lowest-numbered set bit of `isr_out`. `eoi_named` clears bit `eoi_level`, and `eoi_lowest` takes precedence if both are high. A same-cycle acknowledge still sets its own bit.
- R10: A synchronous active-high `rst` clears `irr_out`, `isr_out`, `int_out` and `sel_level` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | 8 | Per-level request (trigger) pulses |
| req_clr | input | 8 | Per-level request withdrawal (untrigger) pulses |
| mask_in | input | 8 | Per-level mask, 1 = masked |
| special_mask | input | 1 | 1 selects special-mask comparison |
| eoi_lowest | input | 1 | Non-specific end-of-interrupt pulse |
| eoi_named | input | 1 | Specific end-of-interrupt pulse |
| eoi_level | input | 3 | Level retired by `eoi_named` |
| ack | input | 1 | Processor acknowledge pulse |
| int_out | output | 1 | Interrupt line to the processor |
| sel_level | output | 3 | Level of the current or last selection |
| irr_out | output | 8 | Pending request bits |
| isr_out | output | 8 | In-service bits |

## Verification
The pending register can receive a set and a clear for the same bit in one cycle. The clear may come from an untrigger or from the selection that takes that very level. A third collision is an acknowledge that lands in the same cycle as an end-of-interrupt. The bench provokes these collisions on purpose: it pulses a request together with its withdrawal while the level is masked, and it issues acknowledge and end-of-interrupt together. It judges the result on `irr_out` and `isr_out` one edge later against a cycle model built from the requirements. A long pseudo-random phase then lets these coincidences arise on their own, with every output compared each cycle.

// File: rtl/nipr_pkg.sv
package nipr_pkg;

    typedef enum logic [1:0] {
        EOI_NONE   = 2'd0,
        EOI_LOWEST = 2'd1,
        EOI_NAMED  = 2'd2
    } eoi_kind_e;

    typedef enum logic {
        SEL_NESTED  = 1'b0,
        SEL_SPECIAL = 1'b1
    } sel_mode_e;

    // non-specific retirement outranks the specific one
    function automatic eoi_kind_e decode_eoi(input logic lowest, input logic named);
        if (lowest)     return EOI_LOWEST;
        else if (named) return EOI_NAMED;
        else            return EOI_NONE;
    endfunction

endpackage

// File: rtl/nipr_pend_reg.sv
module nipr_pend_reg #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] unset_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] take_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;
    logic [N-1:0] drop;
    logic [N-1:0] keep_unmasked;

    // withdrawal only acts on masked levels; selection clears its winner
    assign drop = (unset_i & mask_i) | take_i;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~drop) | set_i;
    end

    assign pend_o        = pend_q;
    assign keep_unmasked = pend_q & unset_i & ~mask_i & ~take_i;

    a_r2_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    a_r3_unmasked_untrigger_ignored: assert property (@(posedge clk) disable iff (rst)
        (|keep_unmasked) |=> ((pend_o & $past(keep_unmasked)) == $past(keep_unmasked)));

endmodule

// File: rtl/nipr_svc_reg.sv
module nipr_svc_reg
    import nipr_pkg::*;
#(
    parameter int unsigned N  = 8,
    localparam int unsigned LW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  eoi_kind_e     eoi_kind,
    input  logic [LW-1:0] eoi_lvl,
    input  logic          ack_fire,
    input  logic [LW-1:0] ack_lvl,
    output logic [N-1:0]  svc_o
);
    logic [N-1:0] svc_q;
    logic [N-1:0] lowest_bit;
    logic [N-1:0] named_bit;
    logic [N-1:0] ack_bit;
    logic [N-1:0] retire;

    assign lowest_bit = svc_q & (~svc_q + N'(1));

    for (genvar i = 0; i < N; i++) begin : g_dec
        assign named_bit[i] = (eoi_lvl == LW'(i));
        assign ack_bit[i]   = ack_fire && (ack_lvl == LW'(i));
    end

    always_comb begin
        unique case (eoi_kind)
            EOI_LOWEST: retire = lowest_bit;
            EOI_NAMED:  retire = named_bit;
            default:    retire = '0;
        endcase
    end

    // retirement first, then the acknowledged level enters service
    always_ff @(posedge clk) begin
        if (rst) svc_q <= '0;
        else     svc_q <= (svc_q & ~retire) | ack_bit;
    end

    assign svc_o = svc_q;

    a_r9_lowest_drops_one: assert property (@(posedge clk) disable iff (rst)
        (eoi_kind == EOI_LOWEST && !ack_fire && svc_o != '0)
        |=> ($countones(svc_o) == $countones($past(svc_o)) - 1));

    a_r9_named_clears: assert property (@(posedge clk) disable iff (rst)
        (eoi_kind == EOI_NAMED && !ack_fire) |=> !svc_o[$past(eoi_lvl)]);

endmodule

// File: rtl/nipr_select.sv
module nipr_select
    import nipr_pkg::*;
#(
    parameter int unsigned N  = 8,
    localparam int unsigned LW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pend_i,
    input  logic [N-1:0]  svc_i,
    input  logic [N-1:0]  mask_i,
    input  sel_mode_e     mode_i,
    output logic [N-1:0]  grant_o,
    output logic          any_o,
    output logic [LW-1:0] idx_o
);
    logic [N-1:0] shadow;   // level covered by itself or a more urgent in-service level
    logic [N-1:0] allowed;
    logic [N-1:0] elig;

    assign shadow[0] = svc_i[0];
    for (genvar i = 1; i < N; i++) begin : g_shadow
        assign shadow[i] = shadow[i-1] | svc_i[i];
    end

    assign allowed = (mode_i == SEL_SPECIAL) ? ~svc_i : ~shadow;
    assign elig    = pend_i & ~mask_i & allowed;
    assign grant_o = elig & (~elig + N'(1));
    assign any_o   = |elig;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_o[i]) idx_o = LW'(i);
        end
    end

endmodule

// File: rtl/nest_prio_resolver.sv
module nest_prio_resolver
    import nipr_pkg::*;
#(
    parameter int unsigned N  = 8,
    localparam int unsigned LW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_set,
    input  logic [N-1:0]  req_clr,
    input  logic [N-1:0]  mask_in,
    input  logic          special_mask,
    input  logic          eoi_lowest,
    input  logic          eoi_named,
    input  logic [LW-1:0] eoi_level,
    input  logic          ack,
    output logic          int_out,
    output logic [LW-1:0] sel_level,
    output logic [N-1:0]  irr_out,
    output logic [N-1:0]  isr_out
);
    logic          int_q;
    logic [LW-1:0] lvl_q;
    logic [N-1:0]  grant;
    logic          any_grant;
    logic [LW-1:0] grant_idx;
    logic          fire;
    logic          ack_fire;
    logic [N-1:0]  take;
    eoi_kind_e     eoi_kind;
    sel_mode_e     mode;

    assign mode     = sel_mode_e'(special_mask);
    assign eoi_kind = decode_eoi(eoi_lowest, eoi_named);
    assign fire     = !int_q && any_grant;
    assign ack_fire = ack && int_q;
    assign take     = fire ? grant : '0;

    nipr_pend_reg #(.N(N)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_i   (req_set),
        .unset_i (req_clr),
        .mask_i  (mask_in),
        .take_i  (take),
        .pend_o  (irr_out)
    );

    nipr_svc_reg #(.N(N)) u_svc (
        .clk      (clk),
        .rst      (rst),
        .eoi_kind (eoi_kind),
        .eoi_lvl  (eoi_level),
        .ack_fire (ack_fire),
        .ack_lvl  (lvl_q),
        .svc_o    (isr_out)
    );

    nipr_select #(.N(N)) u_sel (
        .pend_i  (irr_out),
        .svc_i   (isr_out),
        .mask_i  (mask_in),
        .mode_i  (mode),
        .grant_o (grant),
        .any_o   (any_grant),
        .idx_o   (grant_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            int_q <= 1'b0;
            lvl_q <= '0;
        end else if (fire) begin
            int_q <= 1'b1;
            lvl_q <= grant_idx;
        end else if (ack_fire) begin
            int_q <= 1'b0;
        end
    end

    assign int_out   = int_q;
    assign sel_level = lvl_q;

    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (int_out && !ack) |=> (int_out && $stable(sel_level)));

    a_r8_ack_enters_service: assert property (@(posedge clk) disable iff (rst)
        (int_out && ack) |=> (!int_out && isr_out[$past(sel_level)]));

    a_r5_top_level_blocks: assert property (@(posedge clk) disable iff (rst)
        (!int_out && !special_mask && isr_out[0]) |=> !int_out);

    a_r6_winner_not_in_service: assert property (@(posedge clk) disable iff (rst)
        $rose(int_out) |-> !isr_out[sel_level]);

    a_r4_masked_never_wins: assert property (@(posedge clk) disable iff (rst)
        (!int_out && (irr_out & ~mask_in) == '0) |=> !int_out);

endmodule

// File: tb/nest_prio_resolver_bench.sv
module nest_prio_resolver_bench;
    localparam int CLK_NS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_set = '0, req_clr = '0, mask_in = '0;
    logic       special_mask = 1'b0, eoi_lowest = 1'b0, eoi_named = 1'b0, ack = 1'b0;
    logic [2:0] eoi_level = '0;
    logic       int_out;
    logic [2:0] sel_level;
    logic [7:0] irr_out, isr_out;

    int nchk = 0;
    int nerr = 0;

    // reference state
    logic       m_int;
    logic [2:0] m_lvl;
    logic [7:0] m_irr, m_isr;

    always #(CLK_NS/2) clk = ~clk;

    nest_prio_resolver u_nest_prio_resolver (
        .clk(clk), .rst(rst), .req_set(req_set), .req_clr(req_clr),
        .mask_in(mask_in), .special_mask(special_mask),
        .eoi_lowest(eoi_lowest), .eoi_named(eoi_named), .eoi_level(eoi_level),
        .ack(ack), .int_out(int_out), .sel_level(sel_level),
        .irr_out(irr_out), .isr_out(isr_out)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "int_out",   {7'd0, int_out}, {7'd0, m_int});
        chk(tag, "sel_level", {5'd0, sel_level}, {5'd0, m_lvl});
        chk(tag, "irr_out",   irr_out, m_irr);
        chk(tag, "isr_out",   isr_out, m_isr);
    endtask

    // cycle model written from the requirements
    task automatic model_step(input logic [7:0] s, c, m, input logic sm, ea, eo,
                              input logic [2:0] el, input logic a);
        int win = -1;
        logic [7:0] n_irr, n_isr, tk;
        if (!m_int) begin
            for (int i = 0; i < 8; i++) begin
                logic blocked = 1'b0;
                if (sm) blocked = m_isr[i];
                else for (int j = 0; j <= i; j++) if (m_isr[j]) blocked = 1'b1;
                if (win < 0 && m_irr[i] && !m[i] && !blocked) win = i;
            end
        end
        tk = (win >= 0) ? (8'd1 << win) : 8'd0;
        n_irr = (m_irr & ~((c & m) | tk)) | s;
        n_isr = m_isr;
        if (ea) begin
            for (int i = 0; i < 8; i++) if (n_isr[i]) begin n_isr[i] = 1'b0; break; end
        end else if (eo) n_isr[el] = 1'b0;
        if (a && m_int) n_isr[m_lvl] = 1'b1;
        if (win >= 0) begin m_int = 1'b1; m_lvl = 3'(win); end
        else if (a && m_int) m_int = 1'b0;
        m_irr = n_irr;
        m_isr = n_isr;
    endtask

    task automatic cyc(input logic [7:0] s, c, m, input logic sm, ea, eo,
                       input logic [2:0] el, input logic a, input string tag);
        req_set = s; req_clr = c; mask_in = m; special_mask = sm;
        eoi_lowest = ea; eoi_named = eo; eoi_level = el; ack = a;
        model_step(s, c, m, sm, ea, eo, el, a);
        @(posedge clk); #1;
        compare(tag);
        req_set = '0; req_clr = '0; eoi_lowest = 1'b0; eoi_named = 1'b0; ack = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        m_int = 1'b0; m_lvl = '0; m_irr = '0; m_isr = '0;
        @(posedge clk); #1;
        rst = 1'b0;
        compare("R10");
    endtask

    initial begin
        #(CLK_NS * 150000);
        nerr++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        do_reset();

        // R1: every request pattern, lowest index must win
        for (int p = 1; p < 256; p++) begin
            do_reset();
            cyc(8'(p), 0, 0, 0, 0, 0, 0, 0, "R2");
            cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1");
            chk("R1", "lowest idx", {5'd0, sel_level}, 8'($clog2((p & -p) + 1) - 1));
        end

        // R5 / R6: one level in service, all others requested
        for (int sm = 0; sm < 2; sm++) begin
            for (int lv = 0; lv < 8; lv++) begin
                do_reset();
                cyc(8'd1 << lv, 0, 0, 1'(sm), 0, 0, 0, 0, "R2");
                cyc(0, 0, 0, 1'(sm), 0, 0, 0, 0, "R7");
                cyc(0, 0, 0, 1'(sm), 0, 0, 0, 1, "R8");
                cyc(8'hFF, 0, 0, 1'(sm), 0, 0, 0, 0, sm ? "R6" : "R5");
                cyc(0, 0, 0, 1'(sm), 0, 0, 0, 0, sm ? "R6" : "R5");
                cyc(0, 0, 0, 1'(sm), 0, 0, 0, 0, sm ? "R6" : "R5");
            end
        end

        // R3 / R2 / R4: hold a selection while the pending bits are edited
        do_reset();
        cyc(8'h10, 0, 0, 0, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R7");
        cyc(8'h2A, 0, 0, 0, 0, 0, 0, 0, "R4");
        cyc(0, 8'h28, 8'h08, 0, 0, 0, 0, 0, "R3");
        chk("R3", "masked cleared, unmasked kept", irr_out, 8'h22);
        cyc(8'h20, 8'h20, 8'h20, 0, 0, 0, 0, 0, "R2");
        chk("R2", "set beats untrigger", irr_out, 8'h22);
        cyc(0, 0, 8'h02, 0, 0, 0, 0, 0, "R4");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, "R8");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, "R8");
        cyc(8'h02, 0, 0, 0, 0, 0, 0, 1, "R8");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, "R9");
        cyc(0, 0, 0, 0, 0, 1, 3'd4, 0, "R9");
        cyc(0, 0, 0, 0, 1, 1, 3'd2, 1, "R9");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R7");

        // mixed traffic, every output compared each cycle
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r = $urandom;
            cyc(r[7:0] & r[15:8], r[23:16] & {8{r[24]}}, {r[3:0], r[31:28]} & {8{r[25]}},
                r[26], r[27] & r[28], r[29] & r[30], r[2:0], r[31] | r[5], "R7");
        end

        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule